// File: doc/BRIEF.md
# LCD Column Driver Line Controller

This block is the digital front end of a column driver for an active-matrix panel. While a load enable is high and the strobe is low, each clock brings in six gray codes of 6 bits each, which is two RGB pixels. Three codes arrive on port A and three on port B. Each port can invert its codes bit by bit, under its own control. The codes fill a line register one group of six columns at a time. A column pointer picks the group and advances after each load.

When the strobe falls, the finished line moves into an output latch. At the same edge the polarity input is captured. It decides which column parity takes the upper reference bank and which takes the lower bank. The same edge starts a high-drive window of 64 or 128 clocks. Each column drives out its latched code, its bank select and a high-impedance enable. A single flag marks the high-drive window for the output amplifiers, which sit outside this block.

Top module: `lcd_col_driver`

## Requirements
- R1: On a load clock, lane k of port A (bits [6k+5:6k], k = 0..2) is stored as column 6g+k, and lane k of port B is stored as column 6g+3+k. Here g is the current group. Column c appears on `colCode[6c+5:6c]`.
- R2: Load clocks (loadEn high, strobe low) fill groups in order from group 0. A clock with loadEn low does not move the pointer. A full line takes NUM_COLS/6 load clocks.
- R3: When invA (or invB) is high on a load clock, the codes from that port are stored bitwise inverted. The other port is not affected.
- R4: Every bit of colHiZ is 1 while the strobe is high. Every bit is also 1 from reset until the first falling strobe.
- R5: The falling strobe is the first clock edge that samples the strobe low after it was high. At that edge, colCode takes the line loaded so far and colHiZ goes to 0.
- R6: colUpperBank[c] = 1 selects the upper bank. With polarity sampled 0 at the falling strobe, even-indexed columns (c = 0, 2, ...) take the upper bank and odd-indexed columns take the lower bank. With polarity sampled 1, the assignment is swapped.
- R7: Load clocks after the last group has been written have no effect on the line until the pointer restarts at the next falling strobe.
- R8: driveHigh is 1 for exactly SHORT_WIN clocks (64 by default) after a falling strobe when extendDrive is sampled 0 at that edge. It is 1 for exactly LONG_WIN clocks (128 by default) when extendDrive is sampled 1. Tying extendDrive low gives the standard, shorter window.
- R9: colCode and colUpperBank hold from one falling strobe to the next. New loads and changes on the polarity input do not change them in between.
- R10: A strobe that goes high during a window drops driveHigh at once. The next falling strobe starts a full new window.
- R11: While rstN is low at a clock edge (synchronous, active low), the pointer, the line, the latch and the window are cleared. As a result colCode is 0, driveHigh is 0 and every colHiZ bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Line strobe; outputs high impedance while high |
| polarity | input | 1 | Bank swap, sampled at the falling strobe |
| extendDrive | input | 1 | 1 selects the long high-drive window |
| loadEn | input | 1 | Accept the codes on both ports this clock |
| invA | input | 1 | Invert port A codes |
| invB | input | 1 | Invert port B codes |
| dataA | input | 18 | Port A: three 6-bit codes |
| dataB | input | 18 | Port B: three 6-bit codes |
| colCode | output | NUM_COLS*6 | Latched gray code per column |
| colUpperBank | output | NUM_COLS | Per-column reference bank select |
| colHiZ | output | NUM_COLS | Per-column high-impedance enable |
| driveHigh | output | 1 | High-drive window flag |

## Verification
The bench builds the block with 12 columns and windows of 4 and 7 clocks. With only two groups per line, the overrun past the last group (R7) and lines that are only partly loaded are reached in a few clocks. The small windows let the bench measure both mode lengths exactly. They also let it land a strobe inside an active window (R10) and watch the restart. Column ordering, inversion and bank alternation use the same logic at any width, so the short line covers them.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic lineCommit;   // copy line register into output latch
    logic laneWrite;    // store the current lane word at the pointer
  } colCtrl_t;

endpackage

// File: rtl/lcd_col_ctrl.sv
module lcd_col_ctrl
  import lcd_col_pkg::*;
#(
  parameter int GROUPS    = 64,
  parameter int SHORT_WIN = 64,
  parameter int LONG_WIN  = 128,
  localparam int GRP_W    = $clog2(GROUPS + 1),
  localparam int WIN_W    = $clog2(LONG_WIN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobe,
  input  logic             extendDrive,
  input  logic             loadEn,
  output colCtrl_t         ctl,
  output logic [GRP_W-1:0] writeGrp,
  output logic             outValid,
  output logic             driveHigh
);

  logic             strobeQ;
  logic             fallEdge;
  logic [GRP_W-1:0] ptr;
  logic [WIN_W-1:0] winCnt;
  logic             lineFull;

  assign fallEdge = strobeQ & ~strobe;
  assign lineFull = (ptr >= GRP_W'(GROUPS));

  always_comb begin
    ctl.lineCommit = fallEdge;
    ctl.laneWrite  = loadEn & ~strobe & ~fallEdge & ~lineFull;
  end

  assign writeGrp  = ptr;
  assign driveHigh = (winCnt != '0) & ~strobe;

  // Strobe history and output-valid flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      strobeQ <= strobe;
      if (fallEdge) outValid <= 1'b1;
    end
  end

  // Column group pointer
  always_ff @(posedge clk) begin
    if (!rstN)              ptr <= '0;
    else if (fallEdge)      ptr <= '0;
    else if (ctl.laneWrite) ptr <= ptr + GRP_W'(1);
  end

  // High-drive window counter
  always_ff @(posedge clk) begin
    if (!rstN)               winCnt <= '0;
    else if (fallEdge)       winCnt <= extendDrive ? WIN_W'(LONG_WIN) : WIN_W'(SHORT_WIN);
    else if (strobe)         winCnt <= '0;
    else if (winCnt != '0)   winCnt <= winCnt - WIN_W'(1);
  end

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= GRP_W'(GROUPS));

  p_ptr_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> (ptr == '0));

  p_win_short_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !extendDrive) |=> (winCnt == WIN_W'(SHORT_WIN)));

  p_win_long_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && extendDrive) |=> (winCnt == WIN_W'(LONG_WIN)));

  p_win_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> (winCnt == '0));

endmodule

// File: rtl/lcd_col_datapath.sv
module lcd_col_datapath
  import lcd_col_pkg::*;
#(
  parameter int NUM_COLS       = 384,
  parameter int CODE_W         = 6,
  parameter int LANES_PER_PORT = 3,
  localparam int LANES         = 2 * LANES_PER_PORT,
  localparam int GROUPS        = NUM_COLS / LANES,
  localparam int GRP_W         = $clog2(GROUPS + 1),
  localparam int PORT_W        = LANES_PER_PORT * CODE_W,
  localparam int WORD_W        = LANES * CODE_W,
  localparam int LINE_W        = NUM_COLS * CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  colCtrl_t          ctl,
  input  logic [GRP_W-1:0]  writeGrp,
  input  logic              polarity,
  input  logic              invA,
  input  logic              invB,
  input  logic [PORT_W-1:0] dataA,
  input  logic [PORT_W-1:0] dataB,
  output logic [LINE_W-1:0] colCode,
  output logic [NUM_COLS-1:0] colUpperBank
);

  logic [WORD_W-1:0] laneWord;
  logic [LINE_W-1:0] lineReg;
  logic [LINE_W-1:0] outLatch;
  logic              polQ;

  // Port inversion; port A fills the low lanes of a group
  assign laneWord = {dataB ^ {PORT_W{invB}}, dataA ^ {PORT_W{invA}}};

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    always_ff @(posedge clk) begin
      if (!rstN)
        lineReg[g*WORD_W +: WORD_W] <= '0;
      else if (ctl.laneWrite && (writeGrp == GRP_W'(g)))
        lineReg[g*WORD_W +: WORD_W] <= laneWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
      polQ     <= 1'b0;
    end else if (ctl.lineCommit) begin
      outLatch <= lineReg;
      polQ     <= polarity;
    end
  end

  assign colCode = outLatch;

  for (genvar c = 0; c < NUM_COLS; c++) begin : gBank
    localparam logic EVEN_COL = ((c % 2) == 0);
    assign colUpperBank[c] = EVEN_COL ^ polQ;
  end

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineCommit |=> (colCode == $past(lineReg)));

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lineCommit |=> $stable(colUpperBank));

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lineCommit |=> $stable(colCode));

endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver
  import lcd_col_pkg::*;
#(
  parameter int NUM_COLS       = 384,
  parameter int CODE_W         = 6,
  parameter int LANES_PER_PORT = 3,
  parameter int SHORT_WIN      = 64,
  parameter int LONG_WIN       = 128,
  localparam int LANES         = 2 * LANES_PER_PORT,
  localparam int GROUPS        = NUM_COLS / LANES,
  localparam int GRP_W         = $clog2(GROUPS + 1),
  localparam int PORT_W        = LANES_PER_PORT * CODE_W,
  localparam int LINE_W        = NUM_COLS * CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strobe,
  input  logic                polarity,
  input  logic                extendDrive,
  input  logic                loadEn,
  input  logic                invA,
  input  logic                invB,
  input  logic [PORT_W-1:0]   dataA,
  input  logic [PORT_W-1:0]   dataB,
  output logic [LINE_W-1:0]   colCode,
  output logic [NUM_COLS-1:0] colUpperBank,
  output logic [NUM_COLS-1:0] colHiZ,
  output logic                driveHigh
);

  colCtrl_t         ctl;
  logic [GRP_W-1:0] writeGrp;
  logic             outValid;

  lcd_col_ctrl #(
    .GROUPS   (GROUPS),
    .SHORT_WIN(SHORT_WIN),
    .LONG_WIN (LONG_WIN)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .extendDrive(extendDrive),
    .loadEn     (loadEn),
    .ctl        (ctl),
    .writeGrp   (writeGrp),
    .outValid   (outValid),
    .driveHigh  (driveHigh)
  );

  lcd_col_datapath #(
    .NUM_COLS      (NUM_COLS),
    .CODE_W        (CODE_W),
    .LANES_PER_PORT(LANES_PER_PORT)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .writeGrp    (writeGrp),
    .polarity    (polarity),
    .invA        (invA),
    .invB        (invB),
    .dataA       (dataA),
    .dataB       (dataB),
    .colCode     (colCode),
    .colUpperBank(colUpperBank)
  );

  assign colHiZ = {NUM_COLS{strobe | ~outValid}};

  p_drive_off_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> (colHiZ == '0));

endmodule

// File: tb/test_lcd_col_driver.sv
`timescale 1ns/1ps
module test_lcd_col_driver;

  localparam int COLS   = 12;
  localparam int CW     = 6;
  localparam int LPP    = 3;
  localparam int SWIN   = 4;
  localparam int LWIN   = 7;
  localparam int LANES  = 2 * LPP;
  localparam int GROUPS = COLS / LANES;
  localparam int PW     = LPP * CW;
  localparam int LW     = COLS * CW;

  logic clk = 1'b0;
  logic rstN, strobe, polarity, extendDrive, loadEn, invA, invB;
  logic [PW-1:0]   dataA, dataB;
  logic [LW-1:0]   colCode;
  logic [COLS-1:0] colUpperBank, colHiZ;
  logic            driveHigh;

  always #2.5 clk = ~clk;

  lcd_col_driver #(
    .NUM_COLS(COLS), .CODE_W(CW), .LANES_PER_PORT(LPP),
    .SHORT_WIN(SWIN), .LONG_WIN(LWIN)
  ) i_lcd_col_driver (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polarity(polarity),
    .extendDrive(extendDrive), .loadEn(loadEn), .invA(invA), .invB(invB),
    .dataA(dataA), .dataB(dataB), .colCode(colCode),
    .colUpperBank(colUpperBank), .colHiZ(colHiZ), .driveHigh(driveHigh)
  );

  typedef struct {
    logic [LW-1:0] codes;
    logic          pol;
  } lineExp_t;

  lineExp_t      expQ[$];
  logic [LW-1:0] modelLine;
  logic [LW-1:0] lastLine;
  logic          lastPol;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] bankFor(input logic pol);
    logic [COLS-1:0] b;
    for (int c = 0; c < COLS; c++) b[c] = ((c % 2) == 0) ^ pol;
    return b;
  endfunction

  function automatic logic [CW-1:0] pat(input int seed, input int g, input int k);
    return CW'((seed * 7 + g * 13 + k * 5 + 3) & 63);
  endfunction

  // Monitor: on each falling strobe, pop the expected line and compare
  initial begin : monitor
    logic prevS = 1'b0;
    lineExp_t e;
    forever begin
      @(posedge clk);
      if (prevS && !strobe && rstN) begin
        prevS = strobe;
        @(negedge clk);
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", "unexpected commit", "none");
        end else begin
          e = expQ.pop_front();
          chk(colCode == e.codes, "R1/R5 line", $sformatf("%h", colCode), $sformatf("%h", e.codes));
          chk(colUpperBank == bankFor(e.pol), "R6 bank",
              $sformatf("%b", colUpperBank), $sformatf("%b", bankFor(e.pol)));
          chk(colHiZ == '0, "R5 hiz", $sformatf("%b", colHiZ), "0");
          lastLine = e.codes;
          lastPol  = e.pol;
        end
      end else begin
        prevS = strobe;
      end
    end
  end

  // Driver: load groups, updating the bench line model
  task automatic loadLine(input int seed, input bit ia, input bit ib, input int groups, input bit gaps);
    logic [CW-1:0] v;
    for (int g = 0; g < groups; g++) begin
      @(negedge clk);
      loadEn = 1'b1; invA = ia; invB = ib;
      for (int k = 0; k < LANES; k++) begin
        v = pat(seed, g, k);
        if (k < LPP) dataA[k*CW +: CW] = v;
        else         dataB[(k-LPP)*CW +: CW] = v;
        if (g < GROUPS)
          modelLine[(g*LANES + k)*CW +: CW] = v ^ {CW{(k < LPP) ? ia : ib}};
      end
      if (gaps) begin
        @(negedge clk);
        loadEn = 1'b0;
        dataA = '1; dataB = '1;
      end
    end
    @(negedge clk);
    loadEn = 1'b0; invA = 1'b0; invB = 1'b0;
  endtask

  task automatic measureWin(input int want, input string tag);
    int n = 0;
    @(negedge clk);
    while (driveHigh && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk(n == want, tag, $sformatf("%0d", n), $sformatf("%0d", want));
  endtask

  task automatic strobeCycle(input bit pol, input bit ext, input int highCycles);
    lineExp_t e;
    @(negedge clk);
    strobe = 1'b1; polarity = pol; extendDrive = ext;
    e.codes = modelLine; e.pol = pol;
    expQ.push_back(e);
    for (int i = 0; i < highCycles; i++) begin
      @(negedge clk);
      chk(colHiZ == '1, "R4 hiz during strobe", $sformatf("%b", colHiZ), "all ones");
      chk(driveHigh == 1'b0, "R10 no drive during strobe", $sformatf("%b", driveHigh), "0");
    end
    strobe = 1'b0;
    measureWin(ext ? LWIN : SWIN, ext ? "R8 long window" : "R8 short window");
  endtask

  initial begin : main
    lineExp_t e;
    rstN = 1'b0; strobe = 1'b0; polarity = 1'b0; extendDrive = 1'b0;
    loadEn = 1'b0; invA = 1'b0; invB = 1'b0; dataA = '0; dataB = '0;
    modelLine = '0; lastLine = '0; lastPol = 1'b0;
    repeat (3) @(negedge clk);
    chk(colHiZ == '1, "R11 reset hiz", $sformatf("%b", colHiZ), "all ones");
    chk(colCode == '0, "R11 reset code", $sformatf("%h", colCode), "0");
    chk(driveHigh == 1'b0, "R11 reset drive", $sformatf("%b", driveHigh), "0");
    rstN = 1'b1;
    @(negedge clk);
    chk(colHiZ == '1, "R4 hiz before first strobe", $sformatf("%b", colHiZ), "all ones");

    // Plain line, polarity 0, short window
    loadLine(1, 1'b0, 1'b0, GROUPS, 1'b0);
    strobeCycle(1'b0, 1'b0, 2);

    // Hold while new data arrives and polarity moves (R9)
    loadLine(2, 1'b1, 1'b0, GROUPS, 1'b1);
    polarity = 1'b1;
    @(negedge clk);
    chk(colCode == lastLine, "R9 code hold", $sformatf("%h", colCode), $sformatf("%h", lastLine));
    chk(colUpperBank == bankFor(lastPol), "R9 bank hold",
        $sformatf("%b", colUpperBank), $sformatf("%b", bankFor(lastPol)));
    // commit of port A inverted line with gaps (R2, R3), polarity 1, long window
    strobeCycle(1'b1, 1'b1, 1);

    // Port B inverted, overrun past last group ignored (R7)
    loadLine(3, 1'b0, 1'b1, GROUPS + 2, 1'b0);
    strobeCycle(1'b0, 1'b0, 3);

    // Both inverted, partial reload keeps later groups (R2)
    loadLine(4, 1'b1, 1'b1, 1, 1'b0);
    strobeCycle(1'b1, 1'b0, 1);

    // Strobe inside an active window (R10)
    loadLine(5, 1'b0, 1'b0, GROUPS, 1'b0);
    @(negedge clk);
    strobe = 1'b1; polarity = 1'b0; extendDrive = 1'b1;
    e.codes = modelLine; e.pol = 1'b0;
    expQ.push_back(e);
    @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(driveHigh == 1'b1, "R10 window running", $sformatf("%b", driveHigh), "1");
    strobe = 1'b1;
    #1;
    chk(driveHigh == 1'b0, "R10 window cut", $sformatf("%b", driveHigh), "0");
    e.codes = modelLine; e.pol = 1'b0;
    expQ.push_back(e);
    @(negedge clk);
    chk(driveHigh == 1'b0, "R10 window stays cut", $sformatf("%b", driveHigh), "0");
    strobe = 1'b0;
    measureWin(LWIN, "R10 restarted window");

    // Reset mid-operation (R11)
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(colHiZ == '1, "R11 reset hiz", $sformatf("%b", colHiZ), "all ones");
    chk(colCode == '0, "R11 reset code", $sformatf("%h", colCode), "0");
    rstN = 1'b1;
    modelLine = '0;
    strobeCycle(1'b0, 1'b0, 1);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 all commits seen", $sformatf("%0d", expQ.size()), "0");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule